// File: doc/BRIEF.md
# Setup Message Sequencer

This block sits behind the link to a coordinating server and turns a stream of bytes into fixed-size 64-bit control messages. A side-band flag arrives with the bytes and says whether a handle was attached to the message. The sequencer enforces a strict bring-up order. First comes a protocol version, then this node's own identifier, then any number of peer connect and disconnect messages. Bring-up ends when the shared-memory marker (the value -1) arrives. After that the block sits in a run state and keeps handling connect and disconnect traffic.

Vector indices are never carried in a message. The block keeps a table with one counter per peer. The Nth connect seen for a peer binds vector N-1 of that peer, so the attach event reports the counter value before it is incremented. The table starts with a configurable number of peers and grows on demand up to a hard capacity. Every accepted message and every rejected message is reported as a one-cycle event with the peer and vector, or as an error code. Mapping the memory and routing interrupts belong to other logic.

Top module: `setup_msg_seq`

## Requirements
- R1: A message is eight bytes taken on cycles with `in_valid` high, least significant byte first. `in_hnd` is sampled together with the eighth byte, and its value on the other bytes has no effect.
- R2: The first message must equal `PROTO_VER` and carry no handle. Otherwise `err_code` 1 is reported and the block enters the failed state.
- R3: The second message must carry no handle and have bits 63:16 equal to zero. Its low 16 bits then become `own_id`. Otherwise `err_code` 2 is reported and the block enters the failed state.
- R4: With `IS_MASTER` set, an accepted second message whose value is not 0 reports `err_code` 3 and enters the failed state. A value of 0 is accepted.
- R5: After the identifier, a message that is not all ones and has a nonzero bit in 63:16 reports `err_code` 4 and has no other effect.
- R6: A peer value at or above `tbl_size` grows `tbl_size` to value+1. `tbl_size` is `INIT_PEERS` after reset. A peer value at or above `PEER_CAP` reports `err_code` 8 and leaves the table unchanged.
- R7: A message with a handle is a connect. It pulses `ev_attach` with `ev_peer` set to the low 16 bits and `ev_vec` set to that peer's count, then increments the count.
- R8: A connect to a peer whose count already equals `MAX_VEC` reports `err_code` 5 and leaves the count unchanged.
- R9: A message without a handle is a disconnect. It pulses `ev_detach` and clears the peer's count. If the peer equals `own_id`, it reports `err_code` 6 instead, and the count is unchanged.
- R10: The all-ones marker during bring-up pulses `ev_mem` and raises `setup_done`. The same marker in the run state reports `err_code` 7.
- R11: Any error during the peer phase of bring-up enters the failed state, shown as `setup_fail` high. In the failed state every message is ignored. Errors in the run state are only reported, and the state stays the same.
- R12: After reset, `setup_done`, `setup_fail`, every event and `own_id` are zero, and every peer count is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is present this cycle |
| in_byte | input | 8 | Stream byte |
| in_hnd | input | 1 | Handle-attached flag, taken with the eighth byte |
| setup_done | output | 1 | Run state reached |
| setup_fail | output | 1 | Bring-up failed; messages ignored |
| own_id | output | 16 | This node's identifier |
| tbl_size | output | $clog2(PEER_CAP+1) | Current peer table size |
| ev_attach | output | 1 | Vector attach event |
| ev_detach | output | 1 | Peer detach event |
| ev_mem | output | 1 | Shared memory ready event |
| ev_peer | output | 16 | Peer of the attach or detach event |
| ev_vec | output | $clog2(MAX_VEC+1) | Vector of the attach event |
| err_valid | output | 1 | Error event |
| err_code | output | 4 | Error code of the error event |

## Verification
A message completes when its eighth byte is captured at a clock edge. The assembler registers the message at that edge, and the sequencer registers its events, error code and status at the next edge. So each result is due two edges after the last byte and lasts exactly one cycle. The bench drives bytes on falling edges. It drops `in_valid` on the falling edge after the eighth byte and samples on the falling edge after that, which lies inside the one-cycle event window. Peer counts that are not visible directly are read through the `ev_vec` of later connects, and the flag on the first seven bytes is always driven to the opposite value.

// File: rtl/setup_msg_pkg.sv
package setup_msg_pkg;

    localparam int MSG_BYTES = 8;
    localparam int MSG_W     = MSG_BYTES * 8;
    localparam int ID_W      = 16;

    typedef enum logic [2:0] {
        ST_VER   = 3'd0,
        ST_ID    = 3'd1,
        ST_PEERS = 3'd2,
        ST_RUN   = 3'd3,
        ST_FAIL  = 3'd4
    } seq_state_t;

    typedef enum logic [3:0] {
        E_NONE      = 4'd0,
        E_VERSION   = 4'd1,
        E_ID        = 4'd2,
        E_MASTER    = 4'd3,
        E_RANGE     = 4'd4,
        E_VEC_FULL  = 4'd5,
        E_SELF_DISC = 4'd6,
        E_MEM_DUP   = 4'd7,
        E_TBL_OVF   = 4'd8
    } seq_err_t;

    typedef struct packed {
        logic [MSG_W-1:0] val;
        logic             hnd;
    } ctl_msg_t;

    function automatic logic is_mem_marker(input logic [MSG_W-1:0] v);
        return &v;
    endfunction

    function automatic logic fits_id(input logic [MSG_W-1:0] v);
        return v[MSG_W-1:ID_W] == '0;
    endfunction

endpackage

// File: rtl/msg_asm.sv
module msg_asm
    import setup_msg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  logic [7:0] in_byte,
    input  logic     in_hnd,
    output logic     msg_v,
    output ctl_msg_t msg
);
    localparam int BCW = $clog2(MSG_BYTES);

    logic [BCW-1:0]   bcnt_q;
    logic [MSG_W-1:0] shift_q;
    logic [MSG_W-1:0] shift_d;

    assign shift_d = {in_byte, shift_q[MSG_W-1:8]};

    always_ff @(posedge clk) begin
        if (rst) begin
            bcnt_q  <= '0;
            shift_q <= '0;
            msg_v   <= 1'b0;
            msg     <= '0;
        end else begin
            msg_v <= 1'b0;
            if (in_valid) begin
                shift_q <= shift_d;
                if (bcnt_q == BCW'(MSG_BYTES - 1)) begin
                    bcnt_q  <= '0;
                    msg_v   <= 1'b1;
                    msg.val <= shift_d;
                    msg.hnd <= in_hnd;
                end else begin
                    bcnt_q <= bcnt_q + 1'b1;
                end
            end
        end
    end

    // R1
    asm_src_chk: assert property (@(posedge clk) disable iff (rst)
        msg_v |-> $past(in_valid));

endmodule

// File: rtl/peer_tbl.sv
module peer_tbl
    import setup_msg_pkg::*;
#(
    parameter int MAX_VEC    = 4,
    parameter int PEER_CAP   = 32,
    parameter int INIT_PEERS = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ID_W-1:0]               idx,
    input  logic                          grow_en,
    input  logic [$clog2(PEER_CAP+1)-1:0] grow_to,
    input  logic                          inc_en,
    input  logic                          clr_en,
    output logic [$clog2(MAX_VEC+1)-1:0]  rd_cnt,
    output logic [$clog2(PEER_CAP+1)-1:0] size
);
    localparam int CW  = $clog2(MAX_VEC + 1);
    localparam int SW  = $clog2(PEER_CAP + 1);
    localparam int PIW = (PEER_CAP > 1) ? $clog2(PEER_CAP) : 1;

    logic [CW-1:0] cnt_a [PEER_CAP];
    logic          in_rng;

    assign in_rng = {1'b0, idx} < 17'(PEER_CAP);
    assign rd_cnt = in_rng ? cnt_a[idx[PIW-1:0]] : '0;

    for (genvar i = 0; i < PEER_CAP; i++) begin : g_ent
        logic hit;
        assign hit = in_rng && (idx[PIW-1:0] == PIW'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_a[i] <= '0;
            end else if (hit && clr_en) begin
                cnt_a[i] <= '0;
            end else if (hit && inc_en) begin
                cnt_a[i] <= cnt_a[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            size <= SW'(INIT_PEERS);
        end else if (grow_en) begin
            size <= grow_to;
        end
    end

    // R6
    tbl_cap_chk: assert property (@(posedge clk) disable iff (rst)
        grow_en |=> size <= SW'(PEER_CAP));

    // R6
    tbl_mono_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> size >= $past(size));

    // R8
    cnt_lim_chk: assert property (@(posedge clk) disable iff (rst)
        rd_cnt <= CW'(MAX_VEC));

endmodule

// File: rtl/setup_msg_seq.sv
module setup_msg_seq
    import setup_msg_pkg::*;
#(
    parameter logic [63:0] PROTO_VER  = 64'd0,
    parameter int          MAX_VEC    = 4,
    parameter int          PEER_CAP   = 32,
    parameter int          INIT_PEERS = 16,
    parameter bit          IS_MASTER  = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [7:0]                    in_byte,
    input  logic                          in_hnd,
    output logic                          setup_done,
    output logic                          setup_fail,
    output logic [15:0]                   own_id,
    output logic [$clog2(PEER_CAP+1)-1:0] tbl_size,
    output logic                          ev_attach,
    output logic                          ev_detach,
    output logic                          ev_mem,
    output logic [15:0]                   ev_peer,
    output logic [$clog2(MAX_VEC+1)-1:0]  ev_vec,
    output logic                          err_valid,
    output logic [3:0]                    err_code
);
    localparam int CW = $clog2(MAX_VEC + 1);
    localparam int SW = $clog2(PEER_CAP + 1);

    logic       msg_v;
    ctl_msg_t   msg;
    seq_state_t st_q, st_d;
    logic [ID_W-1:0] id_q, id_d;
    logic [ID_W-1:0] peer;
    logic [16:0]     peer17;
    logic            need_grow, ovf;
    logic            grow_en, inc_en, clr_en;
    logic [CW-1:0]   cnt;
    logic            att_d, det_d, mem_d, err_d;
    seq_err_t        code_d;

    msg_asm u_asm (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .in_hnd   (in_hnd),
        .msg_v    (msg_v),
        .msg      (msg)
    );

    peer_tbl #(
        .MAX_VEC    (MAX_VEC),
        .PEER_CAP   (PEER_CAP),
        .INIT_PEERS (INIT_PEERS)
    ) u_tbl (
        .clk     (clk),
        .rst     (rst),
        .idx     (peer),
        .grow_en (grow_en),
        .grow_to (SW'(peer17 + 17'd1)),
        .inc_en  (inc_en),
        .clr_en  (clr_en),
        .rd_cnt  (cnt),
        .size    (tbl_size)
    );

    assign peer      = msg.val[ID_W-1:0];
    assign peer17    = {1'b0, peer};
    assign need_grow = peer17 >= 17'(tbl_size);
    assign ovf       = peer17 >= 17'(PEER_CAP);

    always_comb begin
        st_d    = st_q;
        id_d    = id_q;
        att_d   = 1'b0;
        det_d   = 1'b0;
        mem_d   = 1'b0;
        err_d   = 1'b0;
        code_d  = E_NONE;
        grow_en = 1'b0;
        inc_en  = 1'b0;
        clr_en  = 1'b0;
        if (msg_v) begin
            unique case (st_q)
                ST_VER: begin
                    if (msg.val == PROTO_VER && !msg.hnd) begin
                        st_d = ST_ID;
                    end else begin
                        err_d  = 1'b1;
                        code_d = E_VERSION;
                        st_d   = ST_FAIL;
                    end
                end
                ST_ID: begin
                    if (msg.hnd || !fits_id(msg.val)) begin
                        err_d  = 1'b1;
                        code_d = E_ID;
                        st_d   = ST_FAIL;
                    end else if (IS_MASTER && peer != '0) begin
                        err_d  = 1'b1;
                        code_d = E_MASTER;
                        st_d   = ST_FAIL;
                    end else begin
                        id_d = peer;
                        st_d = ST_PEERS;
                    end
                end
                ST_PEERS, ST_RUN: begin
                    if (is_mem_marker(msg.val)) begin
                        if (st_q == ST_PEERS) begin
                            mem_d = 1'b1;
                            st_d  = ST_RUN;
                        end else begin
                            err_d  = 1'b1;
                            code_d = E_MEM_DUP;
                        end
                    end else if (!fits_id(msg.val)) begin
                        err_d  = 1'b1;
                        code_d = E_RANGE;
                    end else if (ovf) begin
                        err_d  = 1'b1;
                        code_d = E_TBL_OVF;
                    end else begin
                        grow_en = need_grow;
                        if (msg.hnd) begin
                            if (cnt == CW'(MAX_VEC)) begin
                                err_d  = 1'b1;
                                code_d = E_VEC_FULL;
                            end else begin
                                att_d  = 1'b1;
                                inc_en = 1'b1;
                            end
                        end else if (peer == id_q) begin
                            err_d  = 1'b1;
                            code_d = E_SELF_DISC;
                        end else begin
                            det_d  = 1'b1;
                            clr_en = 1'b1;
                        end
                    end
                    if (st_q == ST_PEERS && err_d) begin
                        st_d = ST_FAIL;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_VER;
            id_q      <= '0;
            ev_attach <= 1'b0;
            ev_detach <= 1'b0;
            ev_mem    <= 1'b0;
            ev_peer   <= '0;
            ev_vec    <= '0;
            err_valid <= 1'b0;
            err_code  <= E_NONE;
        end else begin
            st_q      <= st_d;
            id_q      <= id_d;
            ev_attach <= att_d;
            ev_detach <= det_d;
            ev_mem    <= mem_d;
            ev_peer   <= peer;
            ev_vec    <= cnt;
            err_valid <= err_d;
            err_code  <= code_d;
        end
    end

    assign setup_done = (st_q == ST_RUN);
    assign setup_fail = (st_q == ST_FAIL);
    assign own_id     = id_q;

    // R11
    fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        setup_fail |=> setup_fail);

    // R11
    fail_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(setup_fail) && setup_fail) |-> !(ev_attach || ev_detach || ev_mem || err_valid));

    // R10
    run_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        setup_done |=> setup_done);

    // R10
    mem_entry_chk: assert property (@(posedge clk) disable iff (rst)
        ev_mem |-> (setup_done && !$past(setup_done)));

    // R7
    attach_vec_chk: assert property (@(posedge clk) disable iff (rst)
        ev_attach |-> ev_vec < CW'(MAX_VEC));

    // R9
    evt_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_attach, ev_detach, ev_mem, err_valid}));

endmodule

// File: tb/setup_msg_seq_tb_top.sv
`timescale 1ns/1ps
module setup_msg_seq_tb_top;

    localparam logic [63:0] VER = 64'd5;
    localparam int MAXV = 4;
    localparam int CAP  = 32;
    localparam int INIT = 16;
    localparam int SW   = $clog2(CAP + 1);
    localparam int CW   = $clog2(MAXV + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic in_hnd = 1'b0;

    logic          setup_done, setup_fail, ev_attach, ev_detach, ev_mem, err_valid;
    logic [15:0]   own_id, ev_peer;
    logic [SW-1:0] tbl_size;
    logic [CW-1:0] ev_vec;
    logic [3:0]    err_code;

    logic          m_done, m_fail, m_att, m_det, m_mem, m_errv;
    logic [15:0]   m_own, m_peer;
    logic [SW-1:0] m_size;
    logic [CW-1:0] m_vec;
    logic [3:0]    m_code;

    always #2.5 clk = ~clk;

    setup_msg_seq #(.PROTO_VER(VER), .MAX_VEC(MAXV), .PEER_CAP(CAP),
                    .INIT_PEERS(INIT), .IS_MASTER(1'b0)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_hnd(in_hnd),
        .setup_done(setup_done), .setup_fail(setup_fail), .own_id(own_id),
        .tbl_size(tbl_size), .ev_attach(ev_attach), .ev_detach(ev_detach),
        .ev_mem(ev_mem), .ev_peer(ev_peer), .ev_vec(ev_vec),
        .err_valid(err_valid), .err_code(err_code));

    setup_msg_seq #(.PROTO_VER(VER), .MAX_VEC(MAXV), .PEER_CAP(CAP),
                    .INIT_PEERS(INIT), .IS_MASTER(1'b1)) dut_m (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_hnd(in_hnd),
        .setup_done(m_done), .setup_fail(m_fail), .own_id(m_own),
        .tbl_size(m_size), .ev_attach(m_att), .ev_detach(m_det),
        .ev_mem(m_mem), .ev_peer(m_peer), .ev_vec(m_vec),
        .err_valid(m_errv), .err_code(m_code));

    int n_chk = 0;
    int n_err = 0;

    // reference model
    int  md_state;
    int  md_id;
    int  md_size;
    int  md_cnt [CAP];
    logic e_att, e_det, e_mem, e_errv;
    int  e_code, e_peer, e_vec;
    string e_tag;

    task automatic model_reset();
        md_state = 0; md_id = 0; md_size = INIT;
        for (int i = 0; i < CAP; i++) md_cnt[i] = 0;
    endtask

    task automatic model_step(input logic [63:0] v, input logic h);
        int p;
        int old;
        e_att = 0; e_det = 0; e_mem = 0; e_errv = 0;
        e_code = 0; e_peer = 0; e_vec = 0; e_tag = "R11";
        old = md_state;
        p = int'(v[15:0]);
        case (md_state)
            0: begin
                e_tag = "R2";
                if (v == VER && !h) md_state = 1;
                else begin e_errv = 1; e_code = 1; md_state = 4; end
            end
            1: begin
                e_tag = "R3";
                if (!h && v[63:16] == 48'd0) begin md_id = p; md_state = 2; end
                else begin e_errv = 1; e_code = 2; md_state = 4; end
            end
            2, 3: begin
                if (v == '1) begin
                    e_tag = "R10";
                    if (md_state == 2) begin e_mem = 1; md_state = 3; end
                    else begin e_errv = 1; e_code = 7; end
                end else if (v[63:16] != 48'd0) begin
                    e_tag = "R5"; e_errv = 1; e_code = 4;
                end else if (p >= CAP) begin
                    e_tag = "R6"; e_errv = 1; e_code = 8;
                end else begin
                    if (p >= md_size) begin md_size = p + 1; e_tag = "R6"; end
                    if (h) begin
                        if (md_cnt[p] == MAXV) begin
                            e_tag = "R8"; e_errv = 1; e_code = 5;
                        end else begin
                            if (e_tag != "R6") e_tag = "R7";
                            e_att = 1; e_peer = p; e_vec = md_cnt[p];
                            md_cnt[p]++;
                        end
                    end else if (p == md_id) begin
                        e_tag = "R9"; e_errv = 1; e_code = 6;
                    end else begin
                        if (e_tag != "R6") e_tag = "R9";
                        e_det = 1; e_peer = p; md_cnt[p] = 0;
                    end
                end
                if (old == 2 && e_errv) begin md_state = 4; e_tag = {e_tag, " R11"}; end
            end
            default: ;
        endcase
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
    endtask

    task automatic send_msg(input logic [63:0] v, input logic h);
        for (int b = 0; b < 8; b++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = v[8*b +: 8];
            in_hnd   = (b == 7) ? h : ~h;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_hnd   = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_step(input string pre);
        logic ok;
        ok = (ev_attach == e_att) && (ev_detach == e_det) && (ev_mem == e_mem) &&
             (err_valid == e_errv) && (int'(err_code) == e_code) &&
             (!(e_att || e_det) || int'(ev_peer) == e_peer) &&
             (!e_att || int'(ev_vec) == e_vec) &&
             (setup_done == (md_state == 3)) && (setup_fail == (md_state == 4)) &&
             (md_state < 2 || int'(own_id) == md_id) && (int'(tbl_size) == md_size);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: got att=%0b det=%0b mem=%0b err=%0b code=%0d peer=%0d vec=%0d done=%0b fail=%0b id=%0d size=%0d expected att=%0b det=%0b mem=%0b err=%0b code=%0d peer=%0d vec=%0d done=%0b fail=%0b id=%0d size=%0d",
                pre, e_tag, ev_attach, ev_detach, ev_mem, err_valid, err_code, ev_peer, ev_vec,
                setup_done, setup_fail, own_id, tbl_size,
                e_att, e_det, e_mem, e_errv, e_code, e_peer, e_vec,
                md_state == 3, md_state == 4, md_id, md_size);
        end
    endtask

    task automatic step(input logic [63:0] v, input logic h, input string pre);
        model_step(v, h);
        send_msg(v, h);
        check_step(pre);
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic check_master(input string tag, input logic exp_fail, input int exp_code);
        n_chk++;
        if (m_fail !== exp_fail || int'(m_code) != exp_code || m_errv !== (exp_code != 0)) begin
            n_err++;
            $display("FAIL %s: got fail=%0b code=%0d errv=%0b expected fail=%0b code=%0d",
                     tag, m_fail, m_code, m_errv, exp_fail, exp_code);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R12 reset state
        model_reset();
        e_att = 0; e_det = 0; e_mem = 0; e_errv = 0; e_code = 0; e_tag = "R12";
        check_step("R12");
        check_bit("R12 own_id zero", own_id == 16'd0, 1'b1);

        // R2 wrong version value, then R11 ignore in failed state
        step(VER + 64'd1, 1'b0, "R2");
        step(64'd5, 1'b1, "R11");
        step(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R11");

        // R2 handle on version
        do_reset();
        step(VER, 1'b1, "R2");

        // R3 handle on ID, R1 flag sampled only with last byte
        do_reset();
        step(VER, 1'b0, "R1");
        step(64'd3, 1'b1, "R3");

        // R3 ID out of range
        do_reset();
        step(VER, 1'b0, "R2");
        step(64'd70000, 1'b0, "R3");

        // R4 master with nonzero ID; R5 range error during setup
        do_reset();
        step(VER, 1'b0, "R2");
        step(64'd3, 1'b0, "R3");
        check_master("R4 master rejects ID 3", 1'b1, 3);
        step(64'h1_0000, 1'b0, "R5");

        // main run with ID 0
        do_reset();
        step(VER, 1'b0, "R2");
        step(64'd0, 1'b0, "R3");
        check_master("R4 master accepts ID 0", 1'b0, 0);
        step(64'd20, 1'b1, "R6");
        step(64'd1, 1'b1, "R7");
        step(64'd5, 1'b0, "R9");
        step(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R10");
        for (int k = 0; k < 3; k++) step(64'd20, 1'b1, "R7");
        step(64'd20, 1'b1, "R8");
        step(64'd20, 1'b0, "R9");
        step(64'd20, 1'b1, "R9");
        step(64'd0, 1'b0, "R9");
        step(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R10");
        step(64'h1_0000, 1'b1, "R5");
        step(64'hFFFF_FFFF_FFFF_FFFE, 1'b0, "R5");
        step(64'd32, 1'b1, "R6");
        step(64'd31, 1'b1, "R6");
        check_bit("R11 run stays after errors", setup_done, 1'b1);

        // random traffic in run state
        for (int k = 0; k < 300; k++) begin
            int sel;
            logic [63:0] v;
            sel = int'($urandom % 100);
            if (sel < 60)      step(64'($urandom % 40), 1'b1, "rnd");
            else if (sel < 85) step(64'($urandom % 40), 1'b0, "rnd");
            else if (sel < 90) step('1, 1'($urandom % 2), "rnd");
            else begin
                v = {$urandom, $urandom};
                v[16] = 1'b1;
                v[63] = 1'b0;
                step(v, 1'($urandom % 2), "rnd");
            end
        end

        // R11 error in peer phase of setup fails bring-up
        do_reset();
        step(VER, 1'b0, "R2");
        step(64'd7, 1'b0, "R3");
        step(64'd7, 1'b0, "R11");
        step(64'd2, 1'b1, "R11");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule